// File: doc/BRIEF.md
# SPI Daisy-Chain Command Sequencer

This block is an SPI master for a string of identical slaves that each take a 16-bit command: an instruction byte followed by a data byte. The slaves share chip select and the serial clock. The data output of each slave feeds the data input of the next. The host hands over one command word per device together with a read/write flag. The sequencer shifts all words out in a single chip-select frame, with the word for the device farthest down the chain sent first. When that frame ends, every slave in the chain holds its own command.

A write takes one frame, and the slaves act on it when chip select rises. A read takes two frames. The first frame loads each slave's read request, with the data byte forced to zero. After a short chip-select high gap, a second frame of no-operation words clocks the answers back out. The sequencer takes the data byte from each returned word and places it in the output slot of the device that produced it.

The command input uses a valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the whole transaction, so the host is held off until the sequencer is idle again. The result side has no back-pressure. `done` pulses once at the end of each transaction, and after a read `rd_data` keeps its value until the next read completes.

Top module: `dchain_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `cmd_ready` is 1, `done` is 0 and `rd_data` is all zeros.
- R2: A command is accepted only on an edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` drops on the next cycle and stays low until the transaction ends. Any `cmd_valid` raised during that time starts no frame and changes no device.
- R3: Each frame has `spi_cs_n` low for exactly 16·N rising edges of `spi_sck`. `spi_sck` is low whenever `spi_cs_n` is high.
- R4: Bits go out MSB first. `spi_mosi` changes only together with a falling `spi_sck` and holds steady while `spi_sck` is high. `spi_miso` is sampled at the rising edge.
- R5: The word for device k is `cmd_words[16k+15:16k]`, and its upper byte is the instruction. A write sends one frame that carries word N-1 first and word 0 last.
- R6: The first frame of a read carries each device's instruction byte followed by a data byte of 8'h00, in the same order as a write.
- R7: The second frame of a read follows a chip-select high time of at least two SCK periods and carries N words of 16'h0000.
- R8: After a read, `rd_data[8k+7:8k]` holds the second byte of the word received in position N-1-k of the second frame, counting from 0 for the first word received. This is the data that device k returned.
- R9: `done` is high for exactly one clock, one cycle after the final rise of `spi_cs_n`. `cmd_ready` is high in that same cycle.
- R10: `rd_data` changes only in a cycle where `done` is high at the end of a read. Write transactions leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_read | input | 1 | 1 = two-frame read, 0 = single-frame write |
| cmd_words | input | 16·N_DEV | Per-device command words, device k at bits 16k+15:16k |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 8·N_DEV | Per-device read data, device k at bits 8k+7:8k |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Shared chip select, active low |
| spi_mosi | output | 1 | Serial data to the first device |
| spi_miso | input | 1 | Serial data from the last device |

## Verification
A wrong bit or half-period counter would appear at the ports within one frame. The bench would see a number of SCK rising edges other than 16·N, or a shifted word at the end of the chain. The most likely result is that a slave executes the wrong address or data when chip select rises. A swapped phase or a mistake in the device-index mapping does not show up during the frame itself. It appears as a read value landing in the wrong `rd_data` slot, or a dummy byte that is not zero, and the bench catches it when `done` pulses. Errors in the sequencing state show up as a missing gap between the two read frames, an extra frame, or `cmd_ready` rising too early, all within a single transaction.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    PH_WRITE = 2'd0,
    PH_REQ   = 2'd1,
    PH_NOP   = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_F1   = 2'd1,
    S_GAP  = 2'd2,
    S_F2   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/dc_clkdiv.sv
module dc_clkdiv #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dc_frame_build.sv
module dc_frame_build
  import dchain_pkg::*;
#(
  parameter int          N_DEV    = 3,
  parameter logic [15:0] NOP_WORD = 16'h0000
) (
  input  logic [N_DEV*CMD_W-1:0] words,
  input  phase_e                 phase,
  output logic [N_DEV*CMD_W-1:0] tx
);
  for (genvar k = 0; k < N_DEV; k++) begin : g_dev
    always_comb begin
      unique case (phase)
        PH_WRITE: tx[k*CMD_W +: CMD_W] = words[k*CMD_W +: CMD_W];
        PH_REQ:   tx[k*CMD_W +: CMD_W] = {words[k*CMD_W + BYTE_W +: BYTE_W], {BYTE_W{1'b0}}};
        default:  tx[k*CMD_W +: CMD_W] = NOP_WORD;
      endcase
    end
  end
endmodule

// File: rtl/dc_frame.sv
module dc_frame #(
  parameter int NBITS = 48,
  parameter int DIV   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NBITS-1:0] tx,
  input  logic             miso,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  output logic [NBITS-1:0] rx,
  output logic             fin
);
  localparam int LAST = 2 * NBITS;
  localparam int HW   = $clog2(LAST + 1);

  logic             act;
  logic             tick;
  logic [HW-1:0]    hcnt;
  logic [NBITS-1:0] sreg;

  dc_clkdiv #(.DIV(DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .run (act),
    .tick(tick)
  );

  assign mosi = sreg[NBITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      cs_n <= 1'b1;
      sck  <= 1'b0;
      sreg <= '0;
      rx   <= '0;
      hcnt <= '0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!act && go) begin
        act  <= 1'b1;
        cs_n <= 1'b0;
        sreg <= tx;
        hcnt <= '0;
      end else if (act && tick) begin
        hcnt <= hcnt + 1'b1;
        if (hcnt == HW'(LAST)) begin
          cs_n <= 1'b1;
          act  <= 1'b0;
          fin  <= 1'b1;
        end else if (!hcnt[0]) begin
          sck <= 1'b1;
          rx  <= {rx[NBITS-2:0], miso};
        end else begin
          sck  <= 1'b0;
          sreg <= {sreg[NBITS-2:0], 1'b0};
        end
      end
    end
  end

  // R4
  mosi_stable_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
endmodule

// File: rtl/dchain_seq.sv
module dchain_seq
  import dchain_pkg::*;
#(
  parameter int          N_DEV    = 3,
  parameter int          DIV      = 2,
  parameter int          GAP_SCK  = 2,
  parameter logic [15:0] NOP_WORD = 16'h0000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic                    cmd_read,
  input  logic [N_DEV*CMD_W-1:0]  cmd_words,
  output logic                    done,
  output logic [N_DEV*BYTE_W-1:0] rd_data,
  output logic                    spi_sck,
  output logic                    spi_cs_n,
  output logic                    spi_mosi,
  input  logic                    spi_miso
);
  localparam int NBITS   = N_DEV * CMD_W;
  localparam int GAP_CYC = GAP_SCK * 2 * DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);

  seq_state_e                state;
  phase_e                    phase;
  logic                      rd_mode;
  logic                      go;
  logic [GW-1:0]             gcnt;
  logic [NBITS-1:0]          cmd_q;
  logic [NBITS-1:0]          tx;
  logic [NBITS-1:0]          rx;
  logic                      fin;
  logic [N_DEV*BYTE_W-1:0]   rd_next;

  dc_frame_build #(.N_DEV(N_DEV), .NOP_WORD(NOP_WORD)) u_build (
    .words(cmd_q),
    .phase(phase),
    .tx   (tx)
  );

  dc_frame #(.NBITS(NBITS), .DIV(DIV)) u_frame (
    .clk (clk),
    .rst (rst),
    .go  (go),
    .tx  (tx),
    .miso(spi_miso),
    .sck (spi_sck),
    .cs_n(spi_cs_n),
    .mosi(spi_mosi),
    .rx  (rx),
    .fin (fin)
  );

  for (genvar k = 0; k < N_DEV; k++) begin : g_unpack
    assign rd_next[k*BYTE_W +: BYTE_W] = rx[k*CMD_W +: BYTE_W];
  end

  assign cmd_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      phase   <= PH_WRITE;
      rd_mode <= 1'b0;
      go      <= 1'b0;
      gcnt    <= '0;
      cmd_q   <= '0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      go   <= 1'b0;
      unique case (state)
        S_IDLE: if (cmd_valid) begin
          cmd_q   <= cmd_words;
          rd_mode <= cmd_read;
          phase   <= cmd_read ? PH_REQ : PH_WRITE;
          go      <= 1'b1;
          state   <= S_F1;
        end
        S_F1: if (fin) begin
          if (rd_mode) begin
            gcnt  <= '0;
            state <= S_GAP;
          end else begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == GW'(GAP_CYC - 1)) begin
            phase <= PH_NOP;
            go    <= 1'b1;
            state <= S_F2;
          end
        end
        S_F2: if (fin) begin
          rd_data <= rd_next;
          done    <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd_ready);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> done);

  // R7
  gap_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_GAP) |-> spi_cs_n);
endmodule

// File: tb/dchain_seq_tb.sv
module dchain_seq_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N   = 3;
  localparam int DIV = 2;
  localparam int NB  = 16 * N;

  logic            clk = 1'b0;
  logic            rst = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic            cmd_read = 1'b0;
  logic [NB-1:0]   cmd_words = '0;
  logic            done;
  logic [8*N-1:0]  rd_data;
  logic            spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  dchain_seq #(.N_DEV(N), .DIV(DIV), .GAP_SCK(2), .NOP_WORD(16'h0000)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_words(cmd_words), .done(done), .rd_data(rd_data),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #2 clk = ~clk;

  // Slave chain model: instruction byte bits 7:6 = 2'b10 write, 2'b01 read, 2'b00 nop; bits 3:0 address.
  logic [15:0] sl_sr  [N];
  logic [7:0]  sl_reg [N][16];
  logic        armed = 1'b0;

  assign spi_miso = sl_sr[N-1][15];

  always @(negedge spi_cs_n) armed <= 1'b1;

  always @(posedge spi_sck or posedge spi_cs_n or posedge rst) begin
    if (rst) begin
      for (int k = 0; k < N; k++) begin
        sl_sr[k] <= '0;
        for (int a = 0; a < 16; a++) sl_reg[k][a] <= '0;
      end
    end else if (spi_cs_n) begin
      if (armed) begin
        for (int k = 0; k < N; k++) begin
          if (sl_sr[k][15:14] == 2'b10) sl_reg[k][sl_sr[k][11:8]] <= sl_sr[k][7:0];
          else if (sl_sr[k][15:14] == 2'b01) sl_sr[k] <= {sl_sr[k][15:8], sl_reg[k][sl_sr[k][11:8]]};
        end
      end
    end else begin
      for (int k = 0; k < N; k++)
        sl_sr[k] <= {sl_sr[k][14:0], (k == 0) ? spi_mosi : sl_sr[k-1][15]};
    end
  end

  // Frame monitor
  logic [NB-1:0] mon_bits;
  int            mon_rises;
  logic [NB-1:0] frames [2];
  int            rises  [2];
  int            fidx;
  time           t_rise, gap_ns;

  always @(posedge spi_sck) begin
    mon_bits  = {mon_bits[NB-2:0], spi_mosi};
    mon_rises = mon_rises + 1;
  end

  always @(negedge spi_cs_n) begin
    mon_rises = 0;
    mon_bits  = '0;
    if (fidx == 1) gap_ns = $time - t_rise;
  end

  always @(posedge spi_cs_n) begin
    if (armed) begin
      if (fidx < 2) begin
        frames[fidx] = mon_bits;
        rises[fidx]  = mon_rises;
      end
      fidx   = fidx + 1;
      t_rise = $time;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      $display("FAIL R9 watchdog expired: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  logic [7:0] exp_reg [N][16];

  function automatic logic [7:0] val(int k, int a, int salt);
    return 8'((k * 37 + a * 11 + 5 + salt * 91) & 8'hFF);
  endfunction

  function automatic logic [NB-1:0] req_mask(logic [NB-1:0] w);
    logic [NB-1:0] m;
    for (int k = 0; k < N; k++) m[16*k +: 16] = {w[16*k+8 +: 8], 8'h00};
    return m;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(done, "R9", "done seen", 64'(done), 64'd1);
  endtask

  task automatic txn(bit rd, logic [NB-1:0] w);
    @(negedge clk);
    fidx      = 0;
    cmd_valid = 1'b1;
    cmd_read  = rd;
    cmd_words = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R2", "ready low after accept", 64'(cmd_ready), 64'd0);
    wait_done();
    chk(cmd_ready, "R9", "ready with done", 64'(cmd_ready), 64'd1);
    chk(fidx == (rd ? 2 : 1), "R2", "frame count", 64'(fidx), 64'(rd ? 2 : 1));
    chk(rises[0] == NB, "R3", "rises frame 1", 64'(rises[0]), 64'(NB));
    if (rd) begin
      chk(frames[0] == req_mask(w), "R6", "request frame bits", 64'(frames[0]), 64'(req_mask(w)));
      chk(rises[1] == NB, "R3", "rises frame 2", 64'(rises[1]), 64'(NB));
      chk(frames[1] == '0, "R7", "nop frame bits", 64'(frames[1]), 64'd0);
      chk(gap_ns >= 2 * 2 * DIV * 4, "R7", "cs high gap ns", 64'(gap_ns), 64'(2 * 2 * DIV * 4));
    end else begin
      chk(frames[0] == w, "R5", "write frame bits", 64'(frames[0]), 64'(w));
    end
    @(negedge clk);
    chk(!done, "R9", "done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    logic [NB-1:0] w;
    logic [8*N-1:0] held;
    fidx = 0;
    mon_rises = 0;
    mon_bits = '0;
    #1 rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    chk(spi_cs_n && !spi_sck && cmd_ready && !done && rd_data == '0, "R1", "reset state",
        {59'd0, spi_cs_n, spi_sck, cmd_ready, done, |rd_data}, 64'b10100);

    // R5 and R4: write every address of every device
    for (int a = 0; a < 16; a++) begin
      for (int k = 0; k < N; k++) begin
        w[16*k +: 16]  = {4'h8, 4'(a), val(k, a, 0)};
        exp_reg[k][a]  = val(k, a, 0);
      end
      txn(1'b0, w);
    end

    // R8: each device reads a different address
    for (int a = 0; a < 16; a++) begin
      for (int k = 0; k < N; k++) w[16*k +: 16] = {4'h4, 4'((a + k) % 16), 8'hA5};
      txn(1'b1, w);
      for (int k = 0; k < N; k++)
        chk(rd_data[8*k +: 8] == exp_reg[k][(a + k) % 16], "R8", "read byte",
            64'(rd_data[8*k +: 8]), 64'(exp_reg[k][(a + k) % 16]));
    end

    // R10: a write leaves rd_data untouched
    held = rd_data;
    for (int k = 0; k < N; k++) begin
      w[16*k +: 16] = {4'h8, 4'd0, val(k, 0, 1)};
      exp_reg[k][0] = val(k, 0, 1);
    end
    txn(1'b0, w);
    chk(rd_data == held, "R10", "rd_data held over write", 64'(rd_data), 64'(held));

    // R2: valid while busy is ignored
    for (int k = 0; k < N; k++) w[16*k +: 16] = {4'h8, 4'd5, val(k, 5, 2)};
    @(negedge clk);
    fidx = 0;
    cmd_valid = 1'b1; cmd_read = 1'b0; cmd_words = w;
    @(negedge clk);
    cmd_words = '1;
    repeat (40) @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < N; k++) exp_reg[k][5] = val(k, 5, 2);
    wait_done();
    repeat (200) @(negedge clk);
    chk(fidx == 1, "R2", "no extra frame", 64'(fidx), 64'd1);
    chk(frames[0] == w, "R2", "frame not overwritten", 64'(frames[0]), 64'(w));

    // R8: read back addresses 0 and 5 after the later writes
    for (int k = 0; k < N; k++) w[16*k +: 16] = {4'h4, (k == 1) ? 4'd5 : 4'd0, 8'h00};
    txn(1'b1, w);
    for (int k = 0; k < N; k++)
      chk(rd_data[8*k +: 8] == exp_reg[k][(k == 1) ? 5 : 0], "R8", "readback after update",
          64'(rd_data[8*k +: 8]), 64'(exp_reg[k][(k == 1) ? 5 : 0]));

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule